// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a simple processor register bus and a behavioural array of one-time-programmable fuse words. Software reaches it through a control/status register, reached directly or through set and clear aliases. The register holds a target word address, a busy flag, a sticky error flag, a shadow-reload request and a field for the write-unlock code. It also has a timing register that the block holds for an external strobe sequencer, a data register that starts programming, and one readable shadow copy of each fuse word.

To program a word, software writes the unlock code and the address into the control register, then writes the data register. The block keeps its own copy of the address and reads the current contents of the fuse word. It then drops every data bit whose fuse is already blown and shifts the remaining pattern out one bit per cycle, least significant bit first, pulsing a blow strobe for each fuse it burns. A shadow reload copies every fuse word into its shadow register, one word per cycle. Locked words and accesses that break the rules set the error flag. Until software clears that flag, the block refuses every read of a shadow, every program, every reload and every shadow write.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control register, the data register, the timing register and every shadow word read as zero, and the blow strobe is low.
- R2: The control register reads as {unlock[15:0] in bits 31:16, zeros in bits 15:11, reload flag in bit 10, error in bit 9, busy in bit 8, address in bits 7:0}. A write to offset 0x000 loads the address and the unlock field. A write to 0x004 ORs the written bits into them, and a write to 0x008 clears the bits that are 1. A read of any of the three offsets returns the same value.
- R3: A write to the data register (0x020) starts programming only while the unlock field holds 0x3E77. Without that code the write only updates the data register, and no fuse is blown. Each program attempt uses up the code, so the unlock field reads 0 afterwards.
- R4: An accepted program sets busy from the next cycle. The block keeps its own copy of the target address, so control register address writes during busy do not change which word is burned.
- R5: Programming spends one cycle reading the fuse word and then 32 shift cycles, so busy lasts 33 cycles. The blow strobe pulses once for each data bit that is 1 where the fuse bit is still 0, and bits that are already blown produce no pulse.
- R6: While programming, the data register reads back the masked pattern shifted right with zero fill, and it is zero when programming ends. Data register writes while busy are ignored.
- R7: A program of a write-locked word, or of an address at or beyond the word count, sets error. It clears the unlock field, sets no busy and blows no fuse.
- R8: A read of a read-locked shadow word returns 0xBADABADA and sets error.
- R9: Error is sticky and is cleared only by writing bit 9 to 0x008. While it is set, shadow reads return 0xBADABADA and programs, reloads and shadow writes are dropped.
- R10: Writing bit 10 to the set alias starts a reload. During the reload, busy and bit 10 read as 1 for one cycle per word. The reload copies every fuse word into its shadow, and bit 10 clears by itself when the reload ends. Bit 10 written to offset 0x000 has no effect.
- R11: A write to 0x400 + 0x10*n updates shadow word n. If word n is write-locked, or a reload is running, the write sets error and leaves the shadow unchanged.
- R12: A reload request or a data write that arrives while busy is dropped.
- R13: The timing register at 0x010 stores any written value, reads it back and drives it on the timing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wr_lock | input | NWORDS | Per-word program and shadow-write lock |
| rd_lock | input | NWORDS | Per-word read lock |
| blow_o | output | 1 | Pulses once for each fuse bit burned |
| timing_o | output | 32 | Contents of the timing register |

## Verification
The bench programs the same word twice. A design that does not mask against the fuse contents would pulse the strobe for bits that are already blown, so the second program would give too many pulses. It also moves the address field while a program is running: a design without its own address copy would burn the wrong word, and the word would show up after the next reload. The bench then tries each error path: a locked program, an address out of range, a read-locked read, a locked shadow write and a shadow write during a reload. After each one it checks that reads return 0xBADABADA and that reloads and writes are dropped. A design whose error flag were not sticky would let one of these through. A reference model runs beside the design and compares the read data and strobe every cycle, so a busy window that is one cycle off, or data that shifts the wrong way, shows up at once.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int NWORDS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NWORDS-1:0] wr_lock,
  input  logic [NWORDS-1:0] rd_lock,
  output logic              blow_o,
  output logic [31:0]       timing_o
);
  localparam int AW = $clog2(NWORDS);
  localparam logic [8:0] NW9 = 9'(NWORDS);
  localparam logic [15:0] UNLOCK = 16'h3E77;
  localparam logic [31:0] LOCKED_VAL = 32'hBADA_BADA;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_SHIFT, S_RLD} st_t;

  st_t         st;
  logic [7:0]  addr_f;
  logic [15:0] unlock;
  logic        err;
  logic [31:0] timing, dreg;
  logic [AW-1:0] paddr, ridx;
  logic [4:0]  bcnt;
  logic [31:0] shadow [NWORDS];
  logic [31:0] fuse   [NWORDS];

  wire busy  = st != S_IDLE;
  wire rld   = st == S_RLD;
  wire rd    = bus_sel & ~bus_wr;
  wire wrq   = bus_sel & bus_wr;
  wire is_ctrl = bus_addr == 12'h000;
  wire is_set  = bus_addr == 12'h004;
  wire is_clr  = bus_addr == 12'h008;
  wire is_tim  = bus_addr == 12'h010;
  wire is_dat  = bus_addr == 12'h020;

  logic [7:0] sh_w;
  assign sh_w = bus_addr[11:4] - 8'h40;
  wire sh_hit = (bus_addr[11:10] != 2'b00) && ({1'b0, sh_w} < NW9) && (bus_addr[3:0] == 4'h0);
  wire [AW-1:0] sh_idx = sh_w[AW-1:0];

  wire armed  = unlock == UNLOCK;
  wire tgt_ok = ({1'b0, addr_f} < NW9) && !wr_lock[addr_f[AW-1:0]];
  wire dat_ok = wrq & is_dat & ~busy & ~err;
  wire prog_go  = dat_ok & armed & tgt_ok;
  wire prog_bad = dat_ok & armed & ~tgt_ok;
  wire rl_go    = wrq & is_set & bus_wdata[10] & ~busy & ~err;
  wire rd_bad   = rd & sh_hit & ~err & rd_lock[sh_idx];
  wire sh_bad   = wrq & sh_hit & ~err & (rld | wr_lock[sh_idx]);
  wire sh_ok    = wrq & sh_hit & ~err & ~rld & ~wr_lock[sh_idx];
  wire err_clr  = wrq & is_clr & bus_wdata[9];

  wire [31:0] ctrl_val = {unlock, 5'b0, rld, err, busy, addr_f};

  assign blow_o   = (st == S_SHIFT) & dreg[0];
  assign timing_o = timing;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (is_ctrl | is_set | is_clr) bus_rdata = ctrl_val;
      else if (is_tim)               bus_rdata = timing;
      else if (is_dat)               bus_rdata = dreg;
      else if (sh_hit)               bus_rdata = (err | rd_lock[sh_idx]) ? LOCKED_VAL : shadow[sh_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_f <= '0;
      unlock <= '0;
      err    <= 1'b0;
      timing <= '0;
      dreg   <= '0;
      paddr  <= '0;
      ridx   <= '0;
      bcnt   <= '0;
      for (int i = 0; i < NWORDS; i++) begin
        shadow[i] <= '0;
        fuse[i]   <= '0;
      end
    end else begin
      if (err_clr) err <= 1'b0;
      else if (prog_bad | rd_bad | sh_bad) err <= 1'b1;

      if (wrq & is_ctrl) begin
        addr_f <= bus_wdata[7:0];
        unlock <= bus_wdata[31:16];
      end else if (wrq & is_set) begin
        addr_f <= addr_f | bus_wdata[7:0];
        unlock <= unlock | bus_wdata[31:16];
      end else if (wrq & is_clr) begin
        addr_f <= addr_f & ~bus_wdata[7:0];
        unlock <= unlock & ~bus_wdata[31:16];
      end else if (prog_go | prog_bad) begin
        unlock <= '0;
      end

      if (wrq & is_tim) timing <= bus_wdata;
      if (sh_ok) shadow[sh_idx] <= bus_wdata;

      case (st)
        S_IDLE: begin
          if (dat_ok) dreg <= bus_wdata;
          if (prog_go) begin
            paddr <= addr_f[AW-1:0];
            st    <= S_PRE;
          end else if (rl_go) begin
            ridx <= '0;
            st   <= S_RLD;
          end
        end
        S_PRE: begin
          dreg <= dreg & ~fuse[paddr];
          bcnt <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (dreg[0]) fuse[paddr][bcnt] <= 1'b1;
          dreg <= dreg >> 1;
          bcnt <= bcnt + 5'd1;
          if (bcnt == 5'd31) st <= S_IDLE;
        end
        S_RLD: begin
          shadow[ridx] <= fuse[ridx];
          ridx <= ridx + 1'b1;
          if (ridx == AW'(NWORDS - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |=> $stable(paddr));

  assert_no_reblow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blow_o |-> !fuse[paddr][bcnt]);

  assert_shift_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |=> (dreg == ($past(dreg) >> 1)));

  assert_locked_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_bad |=> (err && st == S_IDLE));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  assert_busy_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_PRE || st == S_SHIFT) && wrq && is_set && bus_wdata[10]) |=> (st != S_RLD));
endmodule

// File: tb/otp_fuse_ctrl_bench.sv
module otp_fuse_ctrl_bench;
  localparam int NW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bs = 1'b0, bw = 1'b0;
  logic [11:0] ba = '0;
  logic [31:0] bd = '0;
  logic [NW-1:0] wlk = '0, rlk = '0;
  logic [31:0] bus_rdata, timing_o;
  logic blow_o;

  always #2 clk = ~clk;

  otp_fuse_ctrl #(.NWORDS(NW)) u_otp_fuse_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bs), .bus_wr(bw), .bus_addr(ba),
    .bus_wdata(bd), .bus_rdata(bus_rdata), .wr_lock(wlk), .rd_lock(rlk),
    .blow_o(blow_o), .timing_o(timing_o)
  );

  int checks = 0, errors = 0, nblow = 0;
  string tag = "R1";
  logic [31:0] last_rd;

  // reference model state
  logic [7:0]  m_addr;
  logic [15:0] m_unl;
  logic        m_err;
  logic [31:0] m_tim, m_dat, p_mask;
  logic [31:0] m_sh [NW];
  logic [31:0] m_fu [NW];
  int p_t, r_t, p_a;

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", t, got, exp);
    end
  endtask

  function automatic logic m_busy();
    return (p_t >= 0) || (r_t >= 0);
  endfunction

  function automatic int sh_index(input logic [11:0] a);
    if (a >= 12'h400 && int'(a) < 1024 + 16 * NW && a[3:0] == 4'h0)
      return (int'(a) - 1024) / 16;
    return -1;
  endfunction

  function automatic logic [31:0] m_rd(input logic s, input logic w, input logic [11:0] a);
    int n;
    if (!s || w) return 32'h0;
    if (a == 12'h0 || a == 12'h4 || a == 12'h8)
      return {m_unl, 5'b0, r_t >= 0, m_err, m_busy(), m_addr};
    if (a == 12'h10) return m_tim;
    if (a == 12'h20) begin
      if (p_t >= 1) return p_mask >> (p_t - 1);
      return m_dat;
    end
    n = sh_index(a);
    if (n >= 0) return (m_err || rlk[n]) ? 32'hBADA_BADA : m_sh[n];
    return 32'h0;
  endfunction

  function automatic logic m_blow();
    if (p_t >= 1 && p_t <= 32) return p_mask[p_t - 1];
    return 1'b0;
  endfunction

  task automatic m_init();
    m_addr = '0; m_unl = '0; m_err = 1'b0; m_tim = '0; m_dat = '0; p_mask = '0;
    p_t = -1; r_t = -1; p_a = 0;
    for (int i = 0; i < NW; i++) begin m_sh[i] = '0; m_fu[i] = '0; end
  endtask

  task automatic m_step(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d);
    logic busy0, err0, rl0;
    int n;
    busy0 = m_busy(); err0 = m_err; rl0 = r_t >= 0;
    if (p_t >= 0) begin
      p_t++;
      if (p_t == 33) begin m_fu[p_a] = m_fu[p_a] | p_mask; p_t = -1; m_dat = '0; end
    end
    if (r_t >= 0) begin
      r_t++;
      if (r_t == NW) begin
        for (int i = 0; i < NW; i++) m_sh[i] = m_fu[i];
        r_t = -1;
      end
    end
    n = sh_index(a);
    if (s && w) begin
      if (a == 12'h0) begin m_addr = d[7:0]; m_unl = d[31:16]; end
      else if (a == 12'h4) begin
        m_addr = m_addr | d[7:0]; m_unl = m_unl | d[31:16];
        if (d[10] && !busy0 && !err0) r_t = 0;
      end else if (a == 12'h8) begin
        m_addr = m_addr & ~d[7:0]; m_unl = m_unl & ~d[31:16];
        if (d[9]) m_err = 1'b0;
      end else if (a == 12'h10) m_tim = d;
      else if (a == 12'h20) begin
        if (!busy0 && !err0) begin
          m_dat = d;
          if (m_unl == 16'h3E77) begin
            m_unl = '0;
            if (int'(m_addr) < NW && !wlk[m_addr]) begin
              p_t = 0; p_a = int'(m_addr); p_mask = d & ~m_fu[m_addr];
            end else m_err = 1'b1;
          end
        end
      end else if (n >= 0 && !err0) begin
        if (rl0 || wlk[n]) m_err = 1'b1;
        else m_sh[n] = d;
      end
    end else if (s && !w && n >= 0 && !err0 && rlk[n]) m_err = 1'b1;
  endtask

  task automatic cyc(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d);
    bs = s; bw = w; ba = a; bd = d;
    #1;
    last_rd = bus_rdata;
    check(tag, bus_rdata, m_rd(s, w, a));
    check(tag, {31'b0, blow_o}, {31'b0, m_blow()});
    check(tag, timing_o, m_tim);
    if (blow_o) nblow++;
    @(posedge clk);
    m_step(s, w, a, d);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d);
  endtask

  task automatic rdx(input logic [11:0] a, input logic [31:0] exp, input string t);
    cyc(1'b1, 1'b0, a, 32'h0);
    check(t, last_rd, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_init();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    check("R1 blow", {31'b0, blow_o}, 32'h0);
    rdx(12'h000, 32'h0, "R1 ctrl");
    rdx(12'h020, 32'h0, "R1 data");
    rdx(12'h450, 32'h0, "R1 shadow");
    rdx(12'h010, 32'h0, "R1 timing");

    tag = "R13";
    wr(12'h010, 32'h1234_5678);
    rdx(12'h010, 32'h1234_5678, "R13 readback");
    check("R13 timing_o", timing_o, 32'h1234_5678);

    tag = "R2";
    wr(12'h000, 32'h0000_0005);
    wr(12'h004, 32'h0000_0030);
    rdx(12'h000, 32'h0000_0035, "R2 set alias");
    wr(12'h008, 32'h0000_0010);
    rdx(12'h008, 32'h0000_0025, "R2 clr alias");
    rdx(12'h004, 32'h0000_0025, "R2 set read");

    tag = "R10";
    wr(12'h000, 32'h0000_0425);
    idle(2);
    rdx(12'h000, 32'h0000_0025, "R10 direct bit10 ignored");

    tag = "R3";
    wr(12'h000, 32'h0000_0003);
    nblow = 0;
    wr(12'h020, 32'h0000_00FF);
    idle(40);
    check("R3 no blow unarmed", nblow, 0);
    rdx(12'h020, 32'h0000_00FF, "R3 data stored");
    rdx(12'h000, 32'h0000_0003, "R3 not busy");

    tag = "R4";
    wr(12'h000, 32'h3E77_0003);
    rdx(12'h000, 32'h3E77_0003, "R3 unlock visible");
    nblow = 0;
    wr(12'h020, 32'h0000_00F5);
    rdx(12'h000, 32'h0000_0103, "R4 busy and unlock used");
    wr(12'h000, 32'h3E77_0009);
    tag = "R12";
    wr(12'h004, 32'h0000_0400);
    rdx(12'h000, 32'h3E77_0109, "R12 reload dropped");
    tag = "R6";
    wr(12'h020, 32'h0000_FFFF);
    rdx(12'h020, 32'h0000_000F, "R6 shifted data");
    tag = "R5";
    idle(40);
    check("R5 blow count", nblow, 6);
    rdx(12'h020, 32'h0, "R6 data zero after");
    wr(12'h008, 32'hFFFF_0000);
    rdx(12'h000, 32'h0000_0009, "R2 unlock cleared");

    wr(12'h000, 32'h3E77_0003);
    nblow = 0;
    wr(12'h020, 32'h0000_00FF);
    idle(40);
    check("R5 masked reprogram", nblow, 2);

    tag = "R10";
    wr(12'h004, 32'h0000_0400);
    rdx(12'h000, 32'h0000_0503, "R10 reload busy");
    idle(130);
    rdx(12'h000, 32'h0000_0003, "R10 self clear");
    rdx(12'h430, 32'h0000_00FF, "R10 shadow copy");
    rdx(12'h490, 32'h0, "R4 latched address");

    tag = "R7";
    wlk[7] = 1'b1;
    nblow = 0;
    wr(12'h000, 32'h3E77_0007);
    wr(12'h020, 32'h0000_0001);
    rdx(12'h000, 32'h0000_0207, "R7 locked word");
    tag = "R9";
    rdx(12'h430, 32'hBADA_BADA, "R9 read while error");
    wr(12'h004, 32'h0000_0400);
    rdx(12'h000, 32'h0000_0207, "R9 reload dropped");
    wr(12'h4A0, 32'h0000_0055);
    wr(12'h008, 32'h0000_0200);
    rdx(12'h000, 32'h0000_0007, "R9 cleared");
    rdx(12'h4A0, 32'h0, "R9 shadow write dropped");
    rdx(12'h430, 32'h0000_00FF, "R9 reads restored");

    tag = "R7";
    wr(12'h000, 32'h3E77_00C8);
    wr(12'h020, 32'h0000_0001);
    rdx(12'h000, 32'h0000_02C8, "R7 out of range");
    idle(35);
    check("R7 no blow", nblow, 0);
    wr(12'h008, 32'h0000_0200);

    tag = "R8";
    rlk[3] = 1'b1;
    rdx(12'h430, 32'hBADA_BADA, "R8 locked read");
    rdx(12'h000, 32'h0000_02C8, "R8 error set");
    wr(12'h008, 32'h0000_0200);
    rlk[3] = 1'b0;
    rdx(12'h430, 32'h0000_00FF, "R8 unlocked read");

    tag = "R11";
    wr(12'h4A0, 32'h0000_ABCD);
    rdx(12'h4A0, 32'h0000_ABCD, "R11 shadow write");
    wr(12'h470, 32'h0000_0001);
    rdx(12'h000, 32'h0000_02C8, "R11 locked shadow");
    wr(12'h008, 32'h0000_0200);
    rdx(12'h470, 32'h0, "R11 locked unchanged");
    wr(12'h004, 32'h0000_0400);
    wr(12'h4A0, 32'h0000_0077);
    idle(130);
    rdx(12'h000, 32'h0000_02C8, "R11 write during reload");
    wr(12'h008, 32'h0000_0200);
    rdx(12'h4A0, 32'h0, "R11 reload result");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule